// File: doc/BRIEF.md
# System Reset Sequencer

This block merges the reset sources of a controller into one active-low internal reset. Three raw, asynchronous sources feed it: an active-low external reset pin, an active-high power-up indication and an active-high brown-out flag. Internal reset is held until both the external pin and the power-up indication are inactive. It then stays held for a fixed oscillator-settle interval measured by a counter, and is released on a clock edge so the core can start its boot fetch.

Brown-out handling is off until software sets an enable bit. A detected brown-out either raises a level interrupt or forces a full reset that re-enters the settle phase. A selectable digital filter requires the synchronized brown-out flag to persist for a set number of cycles before it counts. Sticky cause flags record which source produced a reset, and a write-one-to-clear strobe clears each flag.

Top module: `rst_seq_ctrl`

## Requirements
- R1: Driving `ext_rst_ni` low forces `sys_rst_no` low in the same instant, with no clock edge needed, and sets cause bit 0 (external).
- R2: `sys_rst_no` stays low while either `ext_rst_ni` is low or, before the first release, `por_i` is high. The settle phase starts only after the later of the two has gone inactive.
- R3: After the sources go inactive, `sys_rst_no` rises on a clock edge. This happens SETTLE_CYC cycles after the synchronized sources clear, plus the two-flop synchronizer and one state-update cycle.
- R4: After the first release, `por_i` has no effect: `sys_rst_no` stays high and cause bit 1 is not set.
- R5: While `bod_en_i` is low, `bod_i` has no effect on `sys_rst_no`, `bod_irq_o` or cause bit 2.
- R6: With `bod_rst_sel_i`=1 and brown-out enabled, an accepted brown-out drives `sys_rst_no` low and sets cause bit 2 (brown-out). The settle count restarts from zero each cycle the brown-out persists, and release follows SETTLE_CYC cycles after it clears.
- R7: With `bod_rst_sel_i`=0 and brown-out enabled, an accepted brown-out sets `bod_irq_o` without a reset. The level holds until a strobe with bit 2 of `cause_clr_i` set.
- R8: With `bod_filt_en_i`=1, a brown-out pulse shorter than FILT_LEN cycles is ignored. A pulse of FILT_LEN or more cycles is accepted.
- R9: With `bod_filt_en_i`=0, a brown-out pulse of a few cycles is accepted directly.
- R10: `cause_o` holds bit 0 for external, bit 1 for power-up and bit 2 for brown-out. Its value under `rst_ni` is 3'b010. A bit is cleared by a 1 in the same position of `cause_clr_i`, and a set in the same cycle wins over the clear.
- R11: A new external reset during the settle phase returns the block to waiting, and the settle count restarts from zero when the pin is released again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the sequencer's own flops (supply-good) |
| ext_rst_ni | input | 1 | Raw external reset pin, active low |
| por_i | input | 1 | Raw power-up reset indication, active high |
| bod_i | input | 1 | Raw brown-out detector flag, active high |
| bod_en_i | input | 1 | Brown-out handling enable |
| bod_filt_en_i | input | 1 | Brown-out glitch filter enable |
| bod_rst_sel_i | input | 1 | Brown-out response: 1 = reset, 0 = interrupt |
| cause_clr_i | input | 3 | Write-one-to-clear strobe for the cause flags |
| sys_rst_no | output | 1 | Internal reset to the controller, active low |
| bod_irq_o | output | 1 | Brown-out interrupt, level |
| cause_o | output | 3 | Sticky reset cause flags {brown-out, power-up, external} |

## Verification
The assertions assume that the control bits and the clear strobe are synchronous to `clk_i`. The stimulus therefore changes them only at falling clock edges. They also assume SETTLE_CYC is at least 2, so a cleared settle counter cannot complete in the following cycle. The bench keeps raw source pulses at least two cycles wide, so each pulse reliably passes the synchronizer. It holds every brown-out control bit steady for the whole pulse that the control bit governs.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {ST_HOLD, ST_SETTLE, ST_RUN} seq_state_e;
  localparam int CAUSE_W   = 3;
  localparam int CAUSE_EXT = 0;
  localparam int CAUSE_POR = 1;
  localparam int CAUSE_BOD = 2;
endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/bod_glitch_filter.sv
module bod_glitch_filter #(
  parameter int FILT_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bod_s_i,
  input  logic filt_en_i,
  output logic evt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] LEN = CW'(FILT_LEN);

  logic [CW-1:0] run_q;

  // consecutive-high run length, saturating at LEN
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= '0;
    else if (!bod_s_i)    run_q <= '0;
    else if (run_q != LEN) run_q <= run_q + 1'b1;
  end

  assign evt_o = filt_en_i ? (run_q == LEN) : bod_s_i;

  assert_filter_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_en_i && !bod_s_i) |=> (!evt_o || !filt_en_i));
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_CYC = 2_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clear_i)                cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && !clear_i && (cnt_q == LAST);

  initial assert (SETTLE_CYC >= 2);

  assert_restart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !done_o);
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 2_000_000,
  parameter int FILT_LEN   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_rst_ni,
  input  logic               por_i,
  input  logic               bod_i,
  input  logic               bod_en_i,
  input  logic               bod_filt_en_i,
  input  logic               bod_rst_sel_i,
  input  logic [CAUSE_W-1:0] cause_clr_i,
  output logic               sys_rst_no,
  output logic               bod_irq_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam logic [2:0]         SYNC_RST  = 3'b011;  // ext and por asserted
  localparam logic [CAUSE_W-1:0] CAUSE_RST = CAUSE_W'(1) << CAUSE_POR;

  logic [2:0] raw, syn;
  logic ext_s, por_s, bod_s;
  logic bod_evt, bod_ok, bod_rst_evt, bod_irq_evt;
  logic src_hold, booted_q, tmr_clear, tmr_done, irq_q;
  logic [CAUSE_W-1:0] cause_q, cause_set;
  seq_state_e state_q, state_d;

  assign raw = {bod_i, por_i, ~ext_rst_ni};

  rst_sync2 #(.W(3), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );
  assign {bod_s, por_s, ext_s} = syn;

  bod_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .bod_s_i(bod_s),
    .filt_en_i(bod_filt_en_i), .evt_o(bod_evt)
  );

  assign bod_ok      = bod_en_i & bod_evt;
  assign bod_rst_evt = bod_ok & bod_rst_sel_i;
  assign bod_irq_evt = bod_ok & ~bod_rst_sel_i;
  assign src_hold    = ext_s | (por_s & ~booted_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HOLD:   if (!src_hold) state_d = ST_SETTLE;
      ST_SETTLE: if (src_hold) state_d = ST_HOLD;
                 else if (tmr_done) state_d = ST_RUN;
      ST_RUN:    if (src_hold) state_d = ST_HOLD;
                 else if (bod_rst_evt) state_d = ST_SETTLE;
      default:   state_d = ST_HOLD;
    endcase
  end

  assign tmr_clear = (state_q != ST_SETTLE) | bod_rst_evt;

  settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(tmr_clear),
    .run_i(state_q == ST_SETTLE), .done_o(tmr_done)
  );

  assign cause_set = {bod_rst_evt, por_s & ~booted_q, ext_s};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HOLD;
      booted_q <= 1'b0;
      cause_q  <= CAUSE_RST;
      irq_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      if (state_d == ST_RUN) booted_q <= 1'b1;
      cause_q  <= (cause_q & ~cause_clr_i) | cause_set;
      irq_q    <= bod_irq_evt | (irq_q & ~cause_clr_i[CAUSE_BOD]);
    end
  end

  // assertion asynchronous through the pin, release on a clock edge
  assign sys_rst_no = (state_q == ST_RUN) & ext_rst_ni;
  assign bod_irq_o  = irq_q;
  assign cause_o    = cause_q;

  assert_src_blocks_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_hold |=> state_q != ST_RUN);

  assert_release_sync_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_RUN) |-> $past(state_q) == ST_SETTLE);

  assert_por_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (booted_q && state_q == ST_RUN && !ext_s && !bod_rst_evt) |=> state_q == ST_RUN);

  assert_bod_off_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bod_en_i |=> !$rose(bod_irq_o));

  assert_bod_off_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bod_en_i |=> !$rose(cause_o[CAUSE_BOD]));

  assert_irq_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bod_irq_o && !cause_clr_i[CAUSE_BOD]) |=> bod_irq_o);

  assert_bod_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bod_rst_evt |=> state_q != ST_RUN);
endmodule

// File: tb/rst_seq_ctrl_test.sv
module rst_seq_ctrl_test;
  localparam int SC = 40;
  localparam int FL = 8;

  logic clk = 0;
  logic rst_ni = 0, ext_rst_ni = 0, por_i = 1, bod_i = 0;
  logic bod_en_i = 0, bod_filt_en_i = 0, bod_rst_sel_i = 0;
  logic [2:0] cause_clr_i = '0;
  logic sys_rst_no, bod_irq_o;
  logic [2:0] cause_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rst_seq_ctrl #(.SETTLE_CYC(SC), .FILT_LEN(FL)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_rst_ni(ext_rst_ni), .por_i(por_i),
    .bod_i(bod_i), .bod_en_i(bod_en_i), .bod_filt_en_i(bod_filt_en_i),
    .bod_rst_sel_i(bod_rst_sel_i), .cause_clr_i(cause_clr_i),
    .sys_rst_no(sys_rst_no), .bod_irq_o(bod_irq_o), .cause_o(cause_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(output int n);
    n = 0;
    while (!sys_rst_no && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic clear_all();
    cause_clr_i = 3'b111;
    cyc(1);
    cause_clr_i = '0;
    cyc(1);
  endtask

  task automatic t_reset_state();
    cyc(3);
    chk(sys_rst_no == 0, "R2 reset out", sys_rst_no, 0);
    chk(cause_o == 3'b010, "R10 reset cause", cause_o, 3'b010);
    chk(bod_irq_o == 0, "R7 reset irq", bod_irq_o, 0);
    rst_ni = 1;
    cyc(5);
    chk(cause_o == 3'b011, "R1 ext cause", cause_o, 3'b011);
  endtask

  task automatic t_later_source();
    int n;
    ext_rst_ni = 1;
    cyc(SC + 20);
    chk(sys_rst_no == 0, "R2 por still high", sys_rst_no, 0);
    por_i = 0;
    measure(n);
    chk(n >= SC + 1 && n <= SC + 5, "R3 settle length", n, SC + 3);
  endtask

  task automatic t_por_ignored();
    clear_all();
    chk(cause_o == 3'b000, "R10 w1c all", cause_o, 0);
    por_i = 1;
    for (int i = 0; i < 10; i++) begin
      cyc(1);
      chk(sys_rst_no == 1, "R4 por after boot", sys_rst_no, 1);
    end
    por_i = 0;
    cyc(3);
    chk(cause_o[1] == 0, "R4 por cause", cause_o[1], 0);
  endtask

  task automatic t_ext_restart();
    int n;
    ext_rst_ni = 0;
    #1;
    chk(sys_rst_no == 0, "R1 async assert", sys_rst_no, 0);
    cyc(5);
    chk(cause_o[0] == 1, "R1 ext cause", cause_o[0], 1);
    ext_rst_ni = 1;
    cyc(20);
    ext_rst_ni = 0;
    cyc(3);
    ext_rst_ni = 1;
    measure(n);
    chk(n >= SC + 1 && n <= SC + 5, "R11 restart length", n, SC + 3);
    cause_clr_i = 3'b001;
    cyc(1);
    cause_clr_i = '0;
    cyc(1);
    chk(cause_o == 3'b000, "R10 w1c bit0", cause_o, 0);
  endtask

  task automatic t_bod_off();
    bod_en_i = 0; bod_rst_sel_i = 1;
    bod_i = 1;
    cyc(30);
    chk(sys_rst_no == 1, "R5 no reset", sys_rst_no, 1);
    chk(bod_irq_o == 0, "R5 no irq", bod_irq_o, 0);
    chk(cause_o[2] == 0, "R5 no cause", cause_o[2], 0);
    bod_i = 0;
    cyc(5);
    bod_rst_sel_i = 0;
  endtask

  task automatic t_bod_irq();
    bod_en_i = 1; bod_filt_en_i = 0; bod_rst_sel_i = 0;
    cyc(2);
    bod_i = 1;
    cyc(3);
    bod_i = 0;
    cyc(5);
    chk(bod_irq_o == 1, "R9 unfiltered pulse", bod_irq_o, 1);
    chk(sys_rst_no == 1, "R7 no reset", sys_rst_no, 1);
    cyc(10);
    chk(bod_irq_o == 1, "R7 irq held", bod_irq_o, 1);
    cause_clr_i = 3'b100;
    cyc(1);
    cause_clr_i = '0;
    cyc(1);
    chk(bod_irq_o == 0, "R7 irq cleared", bod_irq_o, 0);
  endtask

  task automatic t_bod_filter();
    bod_filt_en_i = 1;
    cyc(2);
    bod_i = 1;
    cyc(FL - 2);
    bod_i = 0;
    cyc(10);
    chk(bod_irq_o == 0, "R8 short pulse", bod_irq_o, 0);
    bod_i = 1;
    cyc(FL + 12);
    bod_i = 0;
    cyc(5);
    chk(bod_irq_o == 1, "R8 long pulse", bod_irq_o, 1);
    clear_all();
    bod_filt_en_i = 0;
  endtask

  task automatic t_bod_reset();
    int n;
    bod_rst_sel_i = 1;
    cyc(2);
    bod_i = 1;
    cyc(6);
    chk(sys_rst_no == 0, "R6 bod reset", sys_rst_no, 0);
    chk(cause_o[2] == 1, "R6 bod cause", cause_o[2], 1);
    chk(bod_irq_o == 0, "R6 no irq", bod_irq_o, 0);
    cyc(SC + 10);
    chk(sys_rst_no == 0, "R6 held while low", sys_rst_no, 0);
    bod_i = 0;
    measure(n);
    chk(n >= SC + 1 && n <= SC + 5, "R6 settle after bod", n, SC + 2);
    cause_clr_i = 3'b100;
    cyc(1);
    cause_clr_i = '0;
    cyc(1);
    chk(cause_o == 3'b000, "R10 w1c bit2", cause_o, 0);
    bod_en_i = 0;
  endtask

  initial begin
    t_reset_state();
    t_later_source();
    t_por_ignored();
    t_ext_restart();
    t_bod_off();
    t_bod_irq();
    t_bod_filter();
    t_bod_reset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R3 act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule